// File: doc/BRIEF.md
# Pin Controller with Per-Pin Function Select

This block owns 54 general purpose pins. A 3-bit selector for each pin makes the pin an input, a plain software-driven output, or a path for one of six alternate-function sources. Software reaches the block over a simple single-cycle register bus. The bus has an address, write and read strobes, write data, and read data that returns one clock after the read strobe.

Software never changes an output level by read-modify-write. One register group raises the output latches for the bits written as one. A second group lowers them. A third group returns the pin levels after a two-stage synchronizer. The alternate-function sources come in as flat vectors of output values and output enables. The vector index is `alt * 54 + pin`.

Top module: `gpio_pinctl`

## Requirements
- R1: After reset every selector is 000, every output latch is low, and `pad_oe` and `pad_out` are all zero.
- R2: A write to byte offset 0x1C (pins 0–31) or 0x20 (pins 32–53) sets the output latch of pin n when data bit n%32 is 1. The new level is visible at the clock edge of the write. Bits written as 0 leave their latches unchanged.
- R3: A write to offset 0x28 (pins 0–31) or 0x2C (pins 32–53) clears the output latch of pin n when data bit n%32 is 1. Bits written as 0 leave their latches unchanged.
- R4: The set and clear offsets read as zero. Unmapped offsets read as zero and ignore writes: 0x18, 0x24, 0x30, 0x3C and above, and any offset that is not a multiple of 4. Set and clear bits 22–31 at offsets 0x20 and 0x2C touch no pin.
- R5: The selector registers at offsets 0x00, 0x04, …, 0x14 can be read and written. Pin i lives in register i/10 at bits (i%10)*3+2 down to (i%10)*3. Bits that hold no pin read as zero: bits 31:30 of every register, and bits 31:12 at offset 0x14.
- R6: Selector 001 drives `pad_oe`=1 and `pad_out` from the pin's latch. Selector 000 drives `pad_oe`=0 and `pad_out`=0.
- R7: The alternate codes map as 100→0, 101→1, 110→2, 111→3, 011→4 and 010→5. For alternate k, `pad_out[i]`=`alt_out[k*54+i]` and `pad_oe[i]`=`alt_oe[k*54+i]`.
- R8: The output latch keeps its level while the pin is not in output mode. Switching the pin to 001 drives the level last written.
- R9: Offsets 0x34 (pins 0–31) and 0x38 (pins 32–53, upper bits zero) return `pad_in` after a two-flop synchronizer. A read strobe issued two or more edges after a `pad_in` change returns the new level.
- R10: `bus_rdata` updates only on the edge that samples `bus_rd` and otherwise holds. When `bus_rd` and `bus_wr` are both high in one cycle, the read returns the register contents from before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_rd` |
| pad_in | input | 54 | Raw pin levels |
| pad_out | output | 54 | Pad output values |
| pad_oe | output | 54 | Pad output enables |
| alt_out | input | 324 | Alternate-function output values, index alt*54+pin |
| alt_oe | input | 324 | Alternate-function output enables, index alt*54+pin |

## Verification
A read and a write can fall on the same edge, because the bus carries both strobes at once. The block must then return the pre-write contents and still commit the write. The bench provokes this in two ways. It raises both strobes together on a selector register holding a known value. It also lets the random phase pair them at any address. The returned word is judged against the bench model before the write is applied, and a later plain read is judged against the model after it. Set and clear writes also meet mode changes of the same pins. Every random operation is followed by a comparison of all pad outputs and enables against the bench's own decoding of selectors, latches and alternate vectors.

// File: rtl/gpio_pinctl_pkg.sv
package gpio_pinctl_pkg;

   localparam int SEL_W   = 3;
   localparam int NUM_ALT = 6;

   // word indices (byte offset / 4) of each register group
   localparam int FSEL_WORD = 0;
   localparam int SET_WORD  = 7;
   localparam int CLR_WORD  = 10;
   localparam int LEV_WORD  = 13;

   typedef enum logic [SEL_W-1:0] {
      PIN_IN   = 3'b000,
      PIN_OUT  = 3'b001,
      PIN_ALT5 = 3'b010,
      PIN_ALT4 = 3'b011,
      PIN_ALT0 = 3'b100,
      PIN_ALT1 = 3'b101,
      PIN_ALT2 = 3'b110,
      PIN_ALT3 = 3'b111
   } pin_fn_e;

   // alternate source index for a selector code (only meaningful for alt codes)
   function automatic int alt_of(logic [SEL_W-1:0] code);
      case (code)
         PIN_ALT0: return 0;
         PIN_ALT1: return 1;
         PIN_ALT2: return 2;
         PIN_ALT3: return 3;
         PIN_ALT4: return 4;
         PIN_ALT5: return 5;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/gpio_pinctl_fsel.sv
module gpio_pinctl_fsel
   import gpio_pinctl_pkg::*;
#(
   parameter int NUM_PINS     = 54,
   parameter int PINS_PER_REG = 10,
   localparam int NUM_REGS    = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG,
   localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int FIELD_W     = SEL_W * PINS_PER_REG
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REGS-1:0]       wr_en,
   input  logic [FIELD_W-1:0]        wr_field,
   input  logic [IDX_W-1:0]          rd_idx,
   output logic [FIELD_W-1:0]        rd_field,
   output logic [NUM_PINS*SEL_W-1:0] sel_o
);

   localparam int SLOTS = 1 << IDX_W;

   if (PINS_PER_REG < 1) begin : g_chk_ppr
      $error("PINS_PER_REG must be at least 1");
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int R = p / PINS_PER_REG;
      localparam int K = p % PINS_PER_REG;
      logic [SEL_W-1:0] sel_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q <= PIN_IN;
         else if (wr_en[R])
            sel_q <= wr_field[K*SEL_W +: SEL_W];
      end

      assign sel_o[p*SEL_W +: SEL_W] = sel_q;
   end

   // pins beyond the last one read as zero through zero extension
   logic [SLOTS*FIELD_W-1:0] sel_pad;
   assign sel_pad  = (SLOTS*FIELD_W)'(sel_o);
   assign rd_field = sel_pad[rd_idx*FIELD_W +: FIELD_W];

endmodule

// File: rtl/gpio_pinctl_latch.sv
module gpio_pinctl_latch #(
   parameter int NUM_PINS  = 54,
   parameter int DATA_W    = 32,
   localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] set_en,
   input  logic [NUM_BANKS-1:0] clr_en,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_PINS-1:0]  lat_o
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int B = p / DATA_W;
      localparam int J = p % DATA_W;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lat_o[p] <= 1'b0;
         else if (set_en[B] && wdata[J])
            lat_o[p] <= 1'b1;
         else if (clr_en[B] && wdata[J])
            lat_o[p] <= 1'b0;
      end
   end

   // ---------------- assertions ----------------
   logic [NUM_BANKS*DATA_W-1:0] lat_pad;
   assign lat_pad = (NUM_BANKS*DATA_W)'(lat_o);

   function automatic logic [DATA_W-1:0] live_mask(int b);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int j = 0; j < DATA_W; j++)
         if (b*DATA_W + j < NUM_PINS) m[j] = 1'b1;
      return m;
   endfunction

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
      localparam logic [DATA_W-1:0] MASK = live_mask(b);

      assert_set_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
         set_en[b] |=> ((lat_pad[b*DATA_W +: DATA_W] & $past(wdata & MASK)) == $past(wdata & MASK)));

      assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
         set_en[b] |=> (((lat_pad[b*DATA_W +: DATA_W] ^ $past(lat_pad[b*DATA_W +: DATA_W]))
                         & ~$past(wdata)) == '0));

      assert_clr_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
         clr_en[b] |=> ((lat_pad[b*DATA_W +: DATA_W] & $past(wdata)) == '0));
   end

   assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|set_en) && !(|clr_en)) |=> $stable(lat_o));

endmodule

// File: rtl/gpio_pinctl_sync.sv
module gpio_pinctl_sync #(
   parameter int WIDTH  = 54,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_chk_stages
      $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= '0;
         else if (s == 0)
            stage_q[s] <= d_i;
         else
            stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pinctl_padmux.sv
module gpio_pinctl_padmux
   import gpio_pinctl_pkg::*;
#(
   parameter int NUM_PINS = 54
) (
   input  logic [NUM_PINS*SEL_W-1:0]   sel_i,
   input  logic [NUM_PINS-1:0]         lat_i,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_out_i,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe_i,
   output logic [NUM_PINS-1:0]         pad_out_o,
   output logic [NUM_PINS-1:0]         pad_oe_o
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [NUM_ALT-1:0] a_out, a_oe;
      logic [SEL_W-1:0]   code;

      for (genvar a = 0; a < NUM_ALT; a++) begin : g_alt
         assign a_out[a] = alt_out_i[a*NUM_PINS + p];
         assign a_oe[a]  = alt_oe_i[a*NUM_PINS + p];
      end

      assign code = sel_i[p*SEL_W +: SEL_W];

      always_comb begin
         case (code)
            PIN_IN: begin
               pad_out_o[p] = 1'b0;
               pad_oe_o[p]  = 1'b0;
            end
            PIN_OUT: begin
               pad_out_o[p] = lat_i[p];
               pad_oe_o[p]  = 1'b1;
            end
            default: begin
               pad_out_o[p] = a_out[alt_of(code)];
               pad_oe_o[p]  = a_oe[alt_of(code)];
            end
         endcase
      end
   end

endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
   import gpio_pinctl_pkg::*;
#(
   parameter int NUM_PINS     = 54,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int PINS_PER_REG = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic                         bus_rd,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [NUM_PINS-1:0]          pad_in,
   output logic [NUM_PINS-1:0]          pad_out,
   output logic [NUM_PINS-1:0]          pad_oe,
   input  logic [NUM_ALT*NUM_PINS-1:0]  alt_out,
   input  logic [NUM_ALT*NUM_PINS-1:0]  alt_oe
);

   localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int NUM_REGS  = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;
   localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int FIELD_W   = SEL_W * PINS_PER_REG;
   localparam int WORD_W    = ADDR_W - 2;

   // ---------------- elaboration checks ----------------
   if (NUM_REGS > SET_WORD - 1) begin : g_chk_regs
      $error("selector registers overlap the set group");
   end
   if (NUM_BANKS > 2) begin : g_chk_banks
      $error("at most two banks fit the register layout");
   end
   if (FIELD_W > DATA_W) begin : g_chk_field
      $error("selector field wider than the data bus");
   end
   if (ADDR_W < 6) begin : g_chk_addr
      $error("ADDR_W too small for the register layout");
   end

   // ---------------- address decode ----------------
   logic [WORD_W-1:0]    word;
   logic                 aligned;
   logic [NUM_REGS-1:0]  fsel_hit;
   logic [NUM_BANKS-1:0] set_hit, clr_hit, lev_hit;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_fsel_dec
      assign fsel_hit[r] = aligned && (word == WORD_W'(FSEL_WORD + r));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
      assign set_hit[b] = aligned && (word == WORD_W'(SET_WORD + b));
      assign clr_hit[b] = aligned && (word == WORD_W'(CLR_WORD + b));
      assign lev_hit[b] = aligned && (word == WORD_W'(LEV_WORD + b));
   end

   // ---------------- storage ----------------
   logic [NUM_PINS*SEL_W-1:0] sel_flat;
   logic [FIELD_W-1:0]        fsel_rd;
   logic [NUM_PINS-1:0]       lat;
   logic [NUM_PINS-1:0]       lev;

   gpio_pinctl_fsel #(
      .NUM_PINS     (NUM_PINS),
      .PINS_PER_REG (PINS_PER_REG)
   ) fsel_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fsel_hit & {NUM_REGS{bus_wr}}),
      .wr_field (bus_wdata[FIELD_W-1:0]),
      .rd_idx   (word[IDX_W-1:0]),
      .rd_field (fsel_rd),
      .sel_o    (sel_flat)
   );

   gpio_pinctl_latch #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W)
   ) latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_hit & {NUM_BANKS{bus_wr}}),
      .clr_en (clr_hit & {NUM_BANKS{bus_wr}}),
      .wdata  (bus_wdata),
      .lat_o  (lat)
   );

   gpio_pinctl_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_in),
      .q_o   (lev)
   );

   gpio_pinctl_padmux #(
      .NUM_PINS (NUM_PINS)
   ) padmux_i (
      .sel_i     (sel_flat),
      .lat_i     (lat),
      .alt_out_i (alt_out),
      .alt_oe_i  (alt_oe),
      .pad_out_o (pad_out),
      .pad_oe_o  (pad_oe)
   );

   // ---------------- read path ----------------
   logic [NUM_BANKS*DATA_W-1:0] lev_pad;
   logic [DATA_W-1:0]           rd_val;

   assign lev_pad = (NUM_BANKS*DATA_W)'(lev);

   always_comb begin
      rd_val = '0;
      if (|fsel_hit)
         rd_val = DATA_W'(fsel_rd);
      for (int b = 0; b < NUM_BANKS; b++)
         if (lev_hit[b])
            rd_val = lev_pad[b*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_val;
   end

   // ---------------- assertions ----------------
   logic wr_no_target;
   assign wr_no_target = bus_wr && !(|fsel_hit) && !(|set_hit) && !(|clr_hit);

   assert_unmapped_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_no_target |=> ($stable(sel_flat) && $stable(lat)));

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
      assert_out_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_flat[p*SEL_W +: SEL_W] == PIN_OUT) |-> (pad_oe[p] && (pad_out[p] == lat[p])));

      assert_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_flat[p*SEL_W +: SEL_W] == PIN_IN) |-> (!pad_oe[p] && !pad_out[p]));
   end

endmodule

// File: tb/gpio_pinctl_tb_top.sv
`timescale 1ns/1ps
module gpio_pinctl_tb_top;

   localparam int NP = 54;
   localparam int NA = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic            bus_rd = 1'b0;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pad_in = '0;
   logic [NP-1:0]   pad_out, pad_oe;
   logic [NA*NP-1:0] alt_out = '0;
   logic [NA*NP-1:0] alt_oe = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model
   logic [2:0]    m_sel [NP];
   logic [NP-1:0] m_lat;

   always #10 clk = ~clk;

   gpio_pinctl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .alt_out   (alt_out),
      .alt_oe    (alt_oe)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
      end
   endtask

   function automatic int alt_idx(logic [2:0] c);
      case (c)
         3'b100: return 0;
         3'b101: return 1;
         3'b110: return 2;
         3'b111: return 3;
         3'b011: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(logic [7:0] a);
      logic [31:0] v;
      int w;
      v = '0;
      w = int'(a[7:2]);
      if (a[1:0] != 2'b00) return '0;
      if (w < 6) begin
         for (int k = 0; k < 10; k++)
            if (w*10 + k < NP) v[k*3 +: 3] = m_sel[w*10 + k];
      end else if (w == 13) v = pad_in[31:0];
      else if (w == 14) v = 32'(pad_in[NP-1:32]);
      return v;
   endfunction

   function automatic void model_write(logic [7:0] a, logic [31:0] d);
      int w;
      w = int'(a[7:2]);
      if (a[1:0] != 2'b00) return;
      if (w < 6) begin
         for (int k = 0; k < 10; k++)
            if (w*10 + k < NP) m_sel[w*10 + k] = d[k*3 +: 3];
      end else if (w == 7 || w == 8) begin
         for (int j = 0; j < 32; j++)
            if ((w-7)*32 + j < NP && d[j]) m_lat[(w-7)*32 + j] = 1'b1;
      end else if (w == 10 || w == 11) begin
         for (int j = 0; j < 32; j++)
            if ((w-10)*32 + j < NP && d[j]) m_lat[(w-10)*32 + j] = 1'b0;
      end
   endfunction

   task automatic check_pads(string req);
      logic [NP-1:0] eo, ee;
      for (int p = 0; p < NP; p++) begin
         case (m_sel[p])
            3'b000: begin eo[p] = 1'b0; ee[p] = 1'b0; end
            3'b001: begin eo[p] = m_lat[p]; ee[p] = 1'b1; end
            default: begin
               eo[p] = alt_out[alt_idx(m_sel[p])*NP + p];
               ee[p] = alt_oe[alt_idx(m_sel[p])*NP + p];
            end
         endcase
      end
      chk(req, "pad_out", 64'(pad_out), 64'(eo));
      chk(req, "pad_oe", 64'(pad_oe), 64'(ee));
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read_chk(string req, logic [7:0] a);
      logic [31:0] d, e;
      e = exp_read(a);
      bus_read(a, d);
      chk(req, $sformatf("read @%h", a), 64'(d), 64'(e));
   endtask

   task automatic randomize_alt();
      for (int i = 0; i < NA*NP; i++) begin
         alt_out[i] = $urandom_range(0, 1) == 1;
         alt_oe[i]  = $urandom_range(0, 1) == 1;
      end
   endtask

   task automatic new_pads();
      pad_in = {22'($urandom), $urandom};
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, e;
      void'($urandom(32'd1357));
      for (int p = 0; p < NP; p++) m_sel[p] = 3'b000;
      m_lat = '0;
      randomize_alt();
      pad_in = {22'h2AAAAA, 32'h5A5A_C3C3};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1", "pad_oe after reset", 64'(pad_oe), 64'd0);
      chk("R1", "pad_out after reset", 64'(pad_out), 64'd0);
      for (int r = 0; r < 6; r++) read_chk("R1", 8'(r*4));

      // R9: level registers through synchronizer
      read_chk("R9", 8'h34);
      read_chk("R9", 8'h38);
      new_pads();
      read_chk("R9", 8'h34);
      read_chk("R9", 8'h38);

      // R6 / R2 / R3: pin 0 in output mode
      bus_write(8'h00, 32'h0000_0001);
      check_pads("R6");
      bus_write(8'h1C, 32'h0000_0001);
      check_pads("R2");
      bus_write(8'h1C, 32'h0000_0000);
      check_pads("R2");
      bus_write(8'h28, 32'h0000_0001);
      check_pads("R3");
      // pins in the upper bank
      bus_write(8'h0C, 32'h0000_0049);          // pins 30,31,32 -> output
      bus_write(8'h10, 32'h0000_0000);
      bus_write(8'h20, 32'h0000_0001);          // pin 32 high
      bus_write(8'h1C, 32'h8000_0000);          // pin 31 high
      check_pads("R2");
      bus_write(8'h2C, 32'h0000_0001);          // pin 32 low
      check_pads("R3");

      // R8: latch keeps its level while the pin is an input
      bus_write(8'h1C, 32'h0000_0020);          // pin 5 latch high, still input
      check_pads("R8");
      bus_write(8'h00, 32'h0000_8001);          // pin 5 -> output
      check_pads("R8");
      chk("R8", "pad_out[5] after switch", 64'(pad_out[5]), 64'd1);

      // R4: set/clear read zero, unmapped ignored, bits above last pin ignored
      read_chk("R4", 8'h1C);
      read_chk("R4", 8'h2C);
      read_chk("R4", 8'h18);
      bus_write(8'h18, 32'hFFFF_FFFF);
      bus_write(8'h3C, 32'hFFFF_FFFF);
      bus_write(8'h01, 32'hFFFF_FFFF);          // misaligned selector access
      bus_write(8'h34, 32'hFFFF_FFFF);
      check_pads("R4");
      read_chk("R4", 8'h00);
      read_chk("R4", 8'h01);
      bus_write(8'h14, 32'h0000_0249);          // pins 50..53 output
      bus_write(8'h20, 32'hFFC0_0000);          // only bits with no pin
      check_pads("R4");
      bus_write(8'h20, 32'h0020_0000);          // pin 53 high
      bus_write(8'h2C, 32'hFFC0_0000);
      check_pads("R4");

      // R5: selector layout and unused bits
      bus_write(8'h14, 32'hFFFF_FFFF);
      read_chk("R5", 8'h14);
      bus_write(8'h08, 32'hFFFF_FFFF);
      read_chk("R5", 8'h08);
      bus_write(8'h04, 32'h1234_5678);
      read_chk("R5", 8'h04);
      bus_write(8'h14, 32'h0000_0000);
      bus_write(8'h08, 32'h0000_0000);

      // R7: every alternate code on pin 33 (register 3, bits 11:9)
      for (int c = 2; c < 8; c++) begin
         bus_write(8'h0C, 32'(c) << 9);
         check_pads("R7");
      end

      // R10: simultaneous read and write returns pre-write contents
      bus_write(8'h04, 32'h0ABC_DEF1);
      e = exp_read(8'h04);
      @(negedge clk);
      bus_addr = 8'h04; bus_wdata = 32'h1111_1111; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      model_write(8'h04, 32'h1111_1111);
      chk("R10", "read during write", 64'(bus_rdata), 64'(e));
      repeat (3) @(negedge clk);
      chk("R10", "rdata holds", 64'(bus_rdata), 64'(e));
      read_chk("R10", 8'h04);
      check_pads("R10");

      // random phase
      for (int it = 0; it < 400; it++) begin
         logic [7:0] a;
         logic [31:0] wd;
         int op;
         a  = 8'($urandom_range(0, 15) * 4);
         if ($urandom_range(0, 7) == 0) a = a + 8'($urandom_range(1, 3));
         wd = $urandom;
         op = $urandom_range(0, 9);
         if (op < 4) begin
            bus_write(a, wd);
            check_pads("R2");
         end else if (op < 7) begin
            read_chk("R5", a);
         end else if (op == 7) begin
            e = exp_read(a);
            @(negedge clk);
            bus_addr = a; bus_wdata = wd; bus_wr = 1'b1; bus_rd = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            model_write(a, wd);
            chk("R10", "random read during write", 64'(bus_rdata), 64'(e));
            check_pads("R10");
         end else if (op == 8) begin
            new_pads();
            read_chk("R9", 8'h34);
            read_chk("R9", 8'h38);
         end else begin
            randomize_alt();
            #1;
            check_pads("R7");
         end
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule